// File: doc/BRIEF.md
# Cause-Tagged Bus Request and Drain Controller

This block keeps track of why a cache wants each of its two bus interfaces: the memory side (toward the next level) and the CPU side (toward the requester). Each interface holds a small vector of request reasons, one bit per cause. An interface asks for its bus whenever any reason is present. The first reason raised on an idle interface also arms a single send attempt for a target cycle, unless that interface is waiting for a retry from its peer. The armed attempt comes out as a one-cycle pulse when a free-running cycle counter reaches or passes the target.

A drain request asks the block to report the moment the cache has gone quiet. Quiet means neither interface holds any reason and both interfaces report empty outgoing queues. Once quiet, the block gives a one-cycle completion pulse, enters a sticky drained state and drops the pending drain. Clearing the last reason is the usual way a waiting drain completes. Arbitration of the buses themselves is left to the surrounding logic.

Top module: `bus_req_drain_ctrl`

## Requirements
- R1: After reset both cause vectors are zero, both request outputs and both send pulses are low, no drain is pending, the drained state is low, and the cycle counter reads zero.
- R2: A set with cause index k (0 miss fill, 1 writeback, 2 coherence, 3 prefetch) makes bit k of that interface's cause vector read 1 in the next cycle. The bit is ORed in regardless of the existing vector, retry state or pending attempt.
- R3: An interface's request output is high exactly when its cause vector is nonzero.
- R4: A set that lands on an all-zero vector, while the interface is not waiting on a retry and holds no armed attempt, arms a send attempt for the supplied target time. The send output then pulses high for one cycle, in the cycle whose counter value equals the target, when the target lies at least one cycle ahead.
- R5: A set that arrives while the vector is already nonzero arms nothing, so no extra send pulse appears.
- R6: A set made while the interface's retry-wait input is high arms nothing. The retry input is looked at only at set time.
- R7: A clear removes only the named bit, one cycle later. When a set and a clear of the same cause coincide, the set wins and the bit stays.
- R8: At most one attempt is armed per interface. A set on an emptied vector while an attempt is still armed is ignored for scheduling, and the earlier target fires alone.
- R9: A target at or before the set cycle, compared modulo the counter width over half its range, fires in the cycle right after the set.
- R10: A drain request clears the drained state and raises drain-pending from the next cycle. On completion, drained goes high and drain-pending low.
- R11: A drain request made while the block is already quiet yields the completion pulse in the very next cycle.
- R12: While a drain is pending, the completion pulse stays low as long as either cause vector is nonzero or either queue-empty input is low. It appears in the cycle after the clear that empties the last vector, or in the same cycle a queue-empty input rises when that input is the last condition.
- R13: The two interfaces are independent: stimulus on one never changes the other's vector or send output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drain_req | input | 1 | Ask for a drain completion report |
| mem_set_valid | input | 1 | Raise a reason on the memory side |
| mem_set_cause | input | CW | Cause index to raise |
| mem_set_time | input | TIME_W | Target cycle for the send attempt |
| mem_clr_valid | input | 1 | Drop a reason on the memory side |
| mem_clr_cause | input | CW | Cause index to drop |
| mem_retry_wait | input | 1 | Memory side is waiting for a retry |
| mem_queues_empty | input | 1 | Memory-side outgoing queues are empty |
| cpu_set_valid | input | 1 | Raise a reason on the CPU side |
| cpu_set_cause | input | CW | Cause index to raise |
| cpu_set_time | input | TIME_W | Target cycle for the send attempt |
| cpu_clr_valid | input | 1 | Drop a reason on the CPU side |
| cpu_clr_cause | input | CW | Cause index to drop |
| cpu_retry_wait | input | 1 | CPU side is waiting for a retry |
| cpu_queues_empty | input | 1 | CPU-side outgoing queues are empty |
| mem_req | output | 1 | Memory side wants its bus |
| mem_causes | output | NUM_CAUSES | Memory-side cause vector |
| mem_send | output | 1 | Memory-side send attempt pulse |
| cpu_req | output | 1 | CPU side wants its bus |
| cpu_causes | output | NUM_CAUSES | CPU-side cause vector |
| cpu_send | output | 1 | CPU-side send attempt pulse |
| drain_pending | output | 1 | A drain is awaiting completion |
| drained_pulse | output | 1 | One-cycle drain completion |
| drained | output | 1 | Sticky drained state |
| cur_time | output | TIME_W | Free-running cycle counter |

## Verification
Every cause index is raised alone on each side with a different lead time. This separates a wrong bit position, a leak into the other interface and an off-by-one in the fire cycle. Ordered pairs of distinct causes show whether a second set re-arms the sender. Retry-blocked sets, past targets and a set on an emptied vector with an attempt still armed cover the three ways scheduling must be suppressed or bounded. The drain tests block completion with each of the four quiet conditions in turn. Removing a vector condition must finish a cycle later, while removing a queue condition finishes in the same cycle, and an idle request finishes one cycle later.

// File: rtl/bus_req_pkg.sv
package bus_req_pkg;

  localparam int unsigned NUM_REQ_CAUSES = 4;

  typedef enum logic [1:0] {
    CAUSE_MISS      = 2'd0,
    CAUSE_WRITEBACK = 2'd1,
    CAUSE_COHERENCE = 2'd2,
    CAUSE_PREFETCH  = 2'd3
  } req_cause_e;

endpackage

// File: rtl/cycle_counter.sv
module cycle_counter #(
  parameter int unsigned TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [TIME_W-1:0] now
);
  logic [TIME_W-1:0] now_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_q + 1'b1;
  end

  assign now = now_q;
endmodule

// File: rtl/req_cause_track.sv
module req_cause_track #(
  parameter int unsigned NUM_CAUSES = bus_req_pkg::NUM_REQ_CAUSES,
  parameter int unsigned TIME_W     = 16,
  localparam int unsigned CW        = (NUM_CAUSES > 1) ? $clog2(NUM_CAUSES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TIME_W-1:0]     now,
  input  logic                  set_valid,
  input  logic [CW-1:0]         set_cause,
  input  logic [TIME_W-1:0]     set_time,
  input  logic                  clr_valid,
  input  logic [CW-1:0]         clr_cause,
  input  logic                  retry_wait,
  output logic [NUM_CAUSES-1:0] causes,
  output logic                  req,
  output logic                  send,
  output logic                  sched_pend
);
  // Target counts as reached when it is not ahead of now (modular, half range).
  function automatic logic time_reached(input logic [TIME_W-1:0] cur,
                                        input logic [TIME_W-1:0] tgt);
    logic [TIME_W-1:0] diff;
    diff = cur - tgt;
    return ~diff[TIME_W-1];
  endfunction

  logic [NUM_CAUSES-1:0] vec_q, vec_d, set_mask, clr_mask;
  logic                  pend_q, pend_d;
  logic [TIME_W-1:0]     tgt_q;
  logic                  arm, fire;

  always_comb begin
    for (int i = 0; i < int'(NUM_CAUSES); i++) begin
      set_mask[i] = set_valid && (set_cause == CW'(i));
      clr_mask[i] = clr_valid && (clr_cause == CW'(i));
    end
  end

  // Set has priority over a clear of the same bit.
  assign vec_d = (vec_q & ~clr_mask) | set_mask;

  assign arm  = set_valid && (vec_q == '0) && !retry_wait && !pend_q;
  assign fire = pend_q && time_reached(now, tgt_q);

  always_comb begin
    pend_d = pend_q;
    if (arm)       pend_d = 1'b1;
    else if (fire) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      pend_q <= 1'b0;
      tgt_q  <= '0;
    end else begin
      vec_q  <= vec_d;
      pend_q <= pend_d;
      if (arm) tgt_q <= set_time;
    end
  end

  assign causes     = vec_q;
  assign req        = |vec_q;
  assign send       = fire;
  assign sched_pend = pend_q;
endmodule

// File: rtl/drain_ctrl.sv
module drain_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic drain_req,
  input  logic mem_busy,
  input  logic cpu_busy,
  input  logic mem_queues_empty,
  input  logic cpu_queues_empty,
  output logic drain_pending,
  output logic drained_pulse,
  output logic drained
);
  logic pend_q, drained_q, can_drain, done;

  assign can_drain = !mem_busy && !cpu_busy && mem_queues_empty && cpu_queues_empty;
  assign done      = pend_q && can_drain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      drained_q <= 1'b0;
    end else begin
      pend_q <= drain_req || (pend_q && !done);
      if (done)           drained_q <= 1'b1;
      else if (drain_req) drained_q <= 1'b0;
    end
  end

  assign drain_pending = pend_q;
  assign drained_pulse = done;
  assign drained       = drained_q;
endmodule

// File: rtl/bus_req_drain_ctrl.sv
module bus_req_drain_ctrl #(
  parameter int unsigned NUM_CAUSES = bus_req_pkg::NUM_REQ_CAUSES,
  parameter int unsigned TIME_W     = 16,
  localparam int unsigned CW        = (NUM_CAUSES > 1) ? $clog2(NUM_CAUSES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  drain_req,
  input  logic                  mem_set_valid,
  input  logic [CW-1:0]         mem_set_cause,
  input  logic [TIME_W-1:0]     mem_set_time,
  input  logic                  mem_clr_valid,
  input  logic [CW-1:0]         mem_clr_cause,
  input  logic                  mem_retry_wait,
  input  logic                  mem_queues_empty,
  input  logic                  cpu_set_valid,
  input  logic [CW-1:0]         cpu_set_cause,
  input  logic [TIME_W-1:0]     cpu_set_time,
  input  logic                  cpu_clr_valid,
  input  logic [CW-1:0]         cpu_clr_cause,
  input  logic                  cpu_retry_wait,
  input  logic                  cpu_queues_empty,
  output logic                  mem_req,
  output logic [NUM_CAUSES-1:0] mem_causes,
  output logic                  mem_send,
  output logic                  cpu_req,
  output logic [NUM_CAUSES-1:0] cpu_causes,
  output logic                  cpu_send,
  output logic                  drain_pending,
  output logic                  drained_pulse,
  output logic                  drained,
  output logic [TIME_W-1:0]     cur_time
);
  logic [TIME_W-1:0] now;
  logic              mem_sched_pend, cpu_sched_pend;

  cycle_counter #(.TIME_W(TIME_W)) u_clock (
    .clk(clk), .rst_n(rst_n), .now(now)
  );

  req_cause_track #(.NUM_CAUSES(NUM_CAUSES), .TIME_W(TIME_W)) u_mem_side (
    .clk(clk), .rst_n(rst_n), .now(now),
    .set_valid(mem_set_valid), .set_cause(mem_set_cause), .set_time(mem_set_time),
    .clr_valid(mem_clr_valid), .clr_cause(mem_clr_cause), .retry_wait(mem_retry_wait),
    .causes(mem_causes), .req(mem_req), .send(mem_send), .sched_pend(mem_sched_pend)
  );

  req_cause_track #(.NUM_CAUSES(NUM_CAUSES), .TIME_W(TIME_W)) u_cpu_side (
    .clk(clk), .rst_n(rst_n), .now(now),
    .set_valid(cpu_set_valid), .set_cause(cpu_set_cause), .set_time(cpu_set_time),
    .clr_valid(cpu_clr_valid), .clr_cause(cpu_clr_cause), .retry_wait(cpu_retry_wait),
    .causes(cpu_causes), .req(cpu_req), .send(cpu_send), .sched_pend(cpu_sched_pend)
  );

  drain_ctrl u_drain (
    .clk(clk), .rst_n(rst_n), .drain_req(drain_req),
    .mem_busy(mem_req), .cpu_busy(cpu_req),
    .mem_queues_empty(mem_queues_empty), .cpu_queues_empty(cpu_queues_empty),
    .drain_pending(drain_pending), .drained_pulse(drained_pulse), .drained(drained)
  );

  assign cur_time = now;
endmodule

// File: rtl/bus_req_drain_chk.sv
module bus_req_drain_chk #(
  parameter int unsigned NUM_CAUSES = 4,
  localparam int unsigned CW        = (NUM_CAUSES > 1) ? $clog2(NUM_CAUSES) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  drain_req,
  input logic                  mem_set_valid,
  input logic [CW-1:0]         mem_set_cause,
  input logic                  mem_clr_valid,
  input logic [CW-1:0]         mem_clr_cause,
  input logic                  mem_retry_wait,
  input logic                  mem_queues_empty,
  input logic                  cpu_set_valid,
  input logic [CW-1:0]         cpu_set_cause,
  input logic                  cpu_clr_valid,
  input logic [CW-1:0]         cpu_clr_cause,
  input logic                  cpu_retry_wait,
  input logic                  cpu_queues_empty,
  input logic                  mem_req,
  input logic [NUM_CAUSES-1:0] mem_causes,
  input logic                  mem_send,
  input logic                  mem_sched_pend,
  input logic                  cpu_req,
  input logic [NUM_CAUSES-1:0] cpu_causes,
  input logic                  cpu_send,
  input logic                  cpu_sched_pend,
  input logic                  drain_pending,
  input logic                  drained_pulse,
  input logic                  drained
);
  a_r2_mem_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
    mem_set_valid |=> mem_causes[$past(mem_set_cause)]);
  a_r2_cpu_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_set_valid |=> cpu_causes[$past(cpu_set_cause)]);

  a_r7_mem_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_clr_valid && !(mem_set_valid && mem_set_cause == mem_clr_cause))
      |=> !mem_causes[$past(mem_clr_cause)]);
  a_r7_cpu_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clr_valid && !(cpu_set_valid && cpu_set_cause == cpu_clr_cause))
      |=> !cpu_causes[$past(cpu_clr_cause)]);

  a_r4_mem_send_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_send |=> !mem_send);
  a_r4_cpu_send_single: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_send |=> !cpu_send);

  a_r5_mem_busy_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_set_valid && mem_req && !mem_sched_pend) |=> !mem_sched_pend);
  a_r6_mem_retry_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_set_valid && mem_retry_wait && !mem_sched_pend) |=> !mem_sched_pend);
  a_r6_cpu_retry_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_set_valid && cpu_retry_wait && !cpu_sched_pend) |=> !cpu_sched_pend);

  a_r12_drain_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    drained_pulse |-> (!mem_req && !cpu_req && mem_queues_empty && cpu_queues_empty));
  a_r11_quiet_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_pending && !mem_req && !cpu_req && mem_queues_empty && cpu_queues_empty)
      |-> drained_pulse);
  a_r10_drain_settles: assert property (@(posedge clk) disable iff (!rst_n)
    (drained_pulse && !drain_req) |=> (drained && !drain_pending));
endmodule

bind bus_req_drain_ctrl bus_req_drain_chk #(.NUM_CAUSES(NUM_CAUSES)) u_chk (.*);

// File: tb/bus_req_drain_ctrl_tb.sv
module bus_req_drain_ctrl_tb;
  import bus_req_pkg::*;
  localparam int NC = 4;
  localparam int CW = 2;
  localparam int TW = 16;

  logic clk = 1'b0, rst_n = 1'b0, drain_req = 1'b0;
  logic mem_set_valid = 0, mem_clr_valid = 0, mem_retry_wait = 0, mem_queues_empty = 1;
  logic cpu_set_valid = 0, cpu_clr_valid = 0, cpu_retry_wait = 0, cpu_queues_empty = 1;
  logic [CW-1:0] mem_set_cause = '0, mem_clr_cause = '0, cpu_set_cause = '0, cpu_clr_cause = '0;
  logic [TW-1:0] mem_set_time = '0, cpu_set_time = '0;
  logic mem_req, mem_send, cpu_req, cpu_send, drain_pending, drained_pulse, drained;
  logic [NC-1:0] mem_causes, cpu_causes;
  logic [TW-1:0] cur_time;

  bus_req_drain_ctrl #(.NUM_CAUSES(NC), .TIME_W(TW)) u_dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int pulses[2] = '{0, 0};
  int last_pulse[2] = '{-1, -1};
  int dpulses = 0, dlast = -1;

  always @(negedge clk) if (rst_n) begin
    if (mem_send) begin pulses[0]++; last_pulse[0] = int'(cur_time); end
    if (cpu_send) begin pulses[1]++; last_pulse[1] = int'(cur_time); end
    if (drained_pulse) begin dpulses++; dlast = int'(cur_time); end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic int causes_of(input int side);
    return (side == 0) ? int'(mem_causes) : int'(cpu_causes);
  endfunction

  function automatic int req_of(input int side);
    return (side == 0) ? int'(mem_req) : int'(cpu_req);
  endfunction

  task automatic apply_set(input int side, input int k, input int d);
    if (side == 0) begin
      mem_set_valid = 1; mem_set_cause = CW'(k); mem_set_time = TW'(int'(cur_time) + d);
    end else begin
      cpu_set_valid = 1; cpu_set_cause = CW'(k); cpu_set_time = TW'(int'(cur_time) + d);
    end
    tick();
    mem_set_valid = 0; cpu_set_valid = 0;
  endtask

  task automatic apply_clr(input int side, input int k);
    if (side == 0) begin mem_clr_valid = 1; mem_clr_cause = CW'(k); end
    else begin cpu_clr_valid = 1; cpu_clr_cause = CW'(k); end
    tick();
    mem_clr_valid = 0; cpu_clr_valid = 0;
  endtask

  task automatic wait_until(input int t);
    while (int'(cur_time) < t) tick();
  endtask

  bit finished = 0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int t0, p0, exp, d0, tr;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check("R1 mem_causes", int'(mem_causes), 0);
    check("R1 cpu_causes", int'(cpu_causes), 0);
    check("R1 req", int'(mem_req) + int'(cpu_req), 0);
    check("R1 send", int'(mem_send) + int'(cpu_send), 0);
    check("R1 drain", int'(drain_pending) + int'(drained) + int'(drained_pulse), 0);
    check("R1 cur_time", int'(cur_time), 0);
    tick();

    // R2 R3 R4 R13: every cause on each side alone
    for (int side = 0; side < 2; side++) begin
      for (int k = 0; k < NC; k++) begin
        t0 = int'(cur_time); p0 = pulses[side]; exp = t0 + 2 + k;
        apply_set(side, k, 2 + k);
        check("R2 cause bit", causes_of(side), 1 << k);
        check("R3 req high", req_of(side), 1);
        check("R13 other side untouched", causes_of(1 - side), 0);
        wait_until(exp + 2);
        check("R4 one pulse", pulses[side] - p0, 1);
        check("R4 pulse cycle", last_pulse[side], exp);
        check("R13 other side no pulse", pulses[1 - side], (side == 0) ? 0 : 4);
        apply_clr(side, k);
        check("R7 cleared", causes_of(side), 0);
        check("R3 req low", req_of(side), 0);
      end
    end

    // R5: second set on a busy vector, every ordered pair
    for (int side = 0; side < 2; side++)
      for (int a = 0; a < NC; a++)
        for (int b = 0; b < NC; b++) if (a != b) begin
          t0 = int'(cur_time); p0 = pulses[side];
          apply_set(side, a, 4);
          apply_set(side, b, 2);
          check("R2 both bits", causes_of(side), (1 << a) | (1 << b));
          wait_until(t0 + 8);
          check("R5 no extra pulse", pulses[side] - p0, 1);
          check("R5 first target kept", last_pulse[side], t0 + 4);
          apply_clr(side, a);
          check("R7 only named bit", causes_of(side), 1 << b);
          apply_clr(side, b);
        end

    // R6: retry wait blocks arming only at set time
    for (int side = 0; side < 2; side++) begin
      p0 = pulses[side];
      if (side == 0) mem_retry_wait = 1; else cpu_retry_wait = 1;
      apply_set(side, int'(CAUSE_COHERENCE), 2);
      mem_retry_wait = 0; cpu_retry_wait = 0;
      repeat (6) tick();
      check("R6 no pulse under retry", pulses[side] - p0, 0);
      check("R6 bit still set", causes_of(side), 4);
      apply_clr(side, int'(CAUSE_COHERENCE));
      t0 = int'(cur_time);
      apply_set(side, int'(CAUSE_PREFETCH), 3);
      wait_until(t0 + 5);
      check("R6 arms after retry ends", last_pulse[side], t0 + 3);
      apply_clr(side, int'(CAUSE_PREFETCH));
    end

    // R9: targets already reached
    for (int side = 0; side < 2; side++)
      for (int d = -3; d <= 1; d += 2) begin
        t0 = int'(cur_time); p0 = pulses[side];
        apply_set(side, int'(CAUSE_MISS), d);
        wait_until(t0 + 4);
        check("R9 late target count", pulses[side] - p0, 1);
        check("R9 late target cycle", last_pulse[side], t0 + 1);
        apply_clr(side, int'(CAUSE_MISS));
      end

    // R8: one armed attempt per interface
    for (int side = 0; side < 2; side++) begin
      t0 = int'(cur_time); p0 = pulses[side];
      apply_set(side, int'(CAUSE_MISS), 10);
      apply_clr(side, int'(CAUSE_MISS));
      apply_set(side, int'(CAUSE_WRITEBACK), 2);
      wait_until(t0 + 14);
      check("R8 single pulse", pulses[side] - p0, 1);
      check("R8 first target", last_pulse[side], t0 + 10);
      apply_clr(side, int'(CAUSE_WRITEBACK));
    end

    // R7: set and clear of the same cause together
    for (int k = 0; k < NC; k++) begin
      mem_clr_valid = 1; mem_clr_cause = CW'(k);
      apply_set(0, k, 2);
      check("R7 set wins", int'(mem_causes), 1 << k);
      apply_clr(0, k);
      repeat (3) tick();
    end

    // R11: drain while already quiet
    tr = int'(cur_time); d0 = dpulses;
    drain_req = 1; tick(); drain_req = 0;
    tick(); tick();
    check("R11 one completion", dpulses - d0, 1);
    check("R11 completion cycle", dlast, tr + 1);
    check("R10 drained set", int'(drained), 1);
    check("R10 pending dropped", int'(drain_pending), 0);

    // R12: each quiet condition blocks in turn
    for (int c = 0; c < 4; c++) begin
      if (c == 0) apply_set(0, int'(CAUSE_WRITEBACK), 2);
      if (c == 1) apply_set(1, int'(CAUSE_MISS), 2);
      if (c == 2) mem_queues_empty = 0;
      if (c == 3) cpu_queues_empty = 0;
      repeat (4) tick();
      d0 = dpulses;
      drain_req = 1; tick(); drain_req = 0;
      check("R10 pending raised", int'(drain_pending), 1);
      check("R10 drained cleared", int'(drained), 0);
      repeat (4) tick();
      check("R12 blocked", dpulses - d0, 0);
      tr = int'(cur_time);
      if (c == 0) begin apply_clr(0, int'(CAUSE_WRITEBACK)); exp = tr + 1; end
      if (c == 1) begin apply_clr(1, int'(CAUSE_MISS)); exp = tr + 1; end
      if (c == 2) begin mem_queues_empty = 1; exp = tr; end
      if (c == 3) begin cpu_queues_empty = 1; exp = tr; end
      repeat (3) tick();
      check("R12 completes once", dpulses - d0, 1);
      check("R12 completion cycle", dlast, exp);
      check("R10 drained after", int'(drained), 1);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule